// File: doc/BRIEF.md
# Windowed Register File

This block is the integer register file of a processor that gives each procedure its own register window. Software sees 32 architectural registers, numbered by 5-bit addresses. Registers 0 to 7 are global and shared by every procedure, and register 0 is hard-wired to zero. Registers 8 to 31 are windowed and lie in a larger physical array of 136 entries: 8 globals plus 8 windows of 16. A 3-bit window pointer decides which part of the array the windowed numbers reach.

The windowed registers form three groups of eight:

- outputs, architectural 8 to 15;
- locals, architectural 16 to 23;
- inputs, architectural 24 to 31.

A procedure call issues `save`, which moves the window down by one. The caller's outputs then appear as the callee's inputs, so arguments pass with no copy. `restore` moves the window back. A small occupancy counter tracks how many windows hold live frames. When a move would overrun the array, the block pulses a flag and leaves the pointer where it was. Spilling frames to memory is left to the surrounding trap logic.

The block has two combinational read ports and one write port that commits at the clock edge. A read of the register being written in the same cycle sees the new data. Every port is a plain addressed access with no handshake. A write or a move is taken on the cycle it is presented and is never stalled.

Top module: `regwin_file`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears every physical register, sets the window pointer to 0 and the live depth to 0, and clears both flags.
- R2: Architectural register 0 always reads zero. A write to it is discarded and is not forwarded to a same-cycle read.
- R3: Architectural registers 1 to 7 reach the same storage whatever the window pointer is.
- R4: With window pointer w, locals 16 to 23 are private to w. Outputs 8+k are the same storage as inputs 24+k of window (w-1) mod 8. A value written to output k before a save therefore reads back from 24+k after it.
- R5: A save alone decrements the pointer modulo 8 and raises the depth by one. A restore alone increments the pointer modulo 8 and lowers the depth by one.
- R6: A save alone while the depth is 6 does not move the pointer or the depth. In that case `ovf` is 1 during the following cycle.
- R7: A restore alone while the depth is 0 does not move the pointer. In that case `unf` is 1 during the following cycle.
- R8: Save and restore asserted together have no effect: no move and no flag.
- R9: A read addressing the register being written in the same cycle returns the write data (write-first).
- R10: A write uses the window pointer in force during its cycle, even when a save or restore is presented in the same cycle.
- R11: Each flag stays high only for the cycle after the command that raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Read port A architectural number |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_addr | input | 5 | Read port B architectural number |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural number |
| wr_data | input | 32 | Write data |
| save | input | 1 | Move window for a call |
| restore | input | 1 | Move window back on return |
| cwp | output | 3 | Current window pointer |
| ovf | output | 1 | Window overflow pulse |
| unf | output | 1 | Window underflow pulse |

## Verification
Assertions check on every cycle:

- the pointer steps taken on save and restore;
- that the pointer freezes and the flag rises on a save at the depth limit or a restore at depth zero;
- that a combined save and restore is inert;
- that the depth stays within its bound;
- that a write lands in the translated entry;
- that globals translate to fixed indices.

Only the bench's scenarios can show the end-to-end data relations: output-to-input passing across a save, privacy of locals across windows, the discarded write to register 0, and forwarding of a write that coincides with a window move. The bench shows these by comparing against its behavioural model.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  typedef enum logic [1:0] {
    GRP_OUT = 2'd0,
    GRP_LOC = 2'd1,
    GRP_IN  = 2'd2,
    GRP_BAD = 2'd3
  } grp_e;
endpackage

// File: rtl/rwf_xlate.sv
module rwf_xlate #(
  parameter int NGLOB  = 8,
  parameter int NPER   = 8,
  parameter int NWIN   = 8,
  parameter int ARCH_W = 5,
  parameter int CWP_W  = 3,
  parameter int PHYS_W = 8
) (
  input  logic [ARCH_W-1:0] arch,
  input  logic [CWP_W-1:0]  cwp,
  output logic [PHYS_W-1:0] phys
);
  import rwf_pkg::*;
  localparam int BLOCK = 2 * NPER;

  logic [CWP_W-1:0] cwp_prev;
  int   k, off, win, base;
  grp_e grp;

  assign cwp_prev = cwp - CWP_W'(1);

  always_comb begin
    k    = 32'(arch) - NGLOB;
    off  = 0;
    win  = 0;
    base = 0;
    grp  = GRP_BAD;
    phys = '0;
    if (32'(arch) < NGLOB) begin
      phys = PHYS_W'(arch);
    end else begin
      off = k % NPER;
      grp = grp_e'(2'(k / NPER));
      case (grp)
        GRP_OUT: begin win = 32'(cwp_prev); base = 0;    end
        GRP_LOC: begin win = 32'(cwp);      base = NPER; end
        default: begin win = 32'(cwp);      base = 0;    end
      endcase
      phys = PHYS_W'(NGLOB + win * BLOCK + base + off);
    end
  end
endmodule

// File: rtl/rwf_winctl.sv
module rwf_winctl #(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save,
  input  logic             restore,
  output logic [CWP_W-1:0] cwp,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CWP_W-1:0] MAXD = CWP_W'(NWIN - 2);

  logic [CWP_W-1:0] depth;
  logic             do_save, do_rest;

  assign do_save = save && !restore;
  assign do_rest = restore && !save;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp   <= '0;
      depth <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (do_save) begin
        if (depth == MAXD) ovf <= 1'b1;
        else begin
          cwp   <= cwp - CWP_W'(1);
          depth <= depth + CWP_W'(1);
        end
      end else if (do_rest) begin
        if (depth == '0) unf <= 1'b1;
        else begin
          cwp   <= cwp + CWP_W'(1);
          depth <= depth - CWP_W'(1);
        end
      end
    end
  end

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_save && depth != MAXD |=> cwp == $past(cwp) - CWP_W'(1) && !ovf); // R5
  AST_REST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    do_rest && depth != '0 |=> cwp == $past(cwp) + CWP_W'(1) && !unf); // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    do_save && depth == MAXD |=> ovf && $stable(cwp) && $stable(depth)); // R6
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    do_rest && depth == '0 |=> unf && $stable(cwp)); // R7
  AST_BOTH_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    save && restore |=> $stable(cwp) && !ovf && !unf); // R8
  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= MAXD); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !save && !restore |=> !ovf && !unf); // R11
endmodule

// File: rtl/rwf_store.sv
module rwf_store #(
  parameter int DATA_W = 32,
  parameter int PHYS   = 136,
  parameter int PHYS_W = 8,
  parameter int NRD    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PHYS_W-1:0]           wr_phys,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NRD-1:0][PHYS_W-1:0]  rd_phys,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] mem [PHYS];
  logic              wr_live;

  assign wr_live = wr_en && (wr_phys != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_phys] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_phys[p] == '0)                      rd_data[p] = '0;
      else if (wr_live && wr_phys == rd_phys[p]) rd_data[p] = wr_data;
      else                                       rd_data[p] = mem[rd_phys[p]];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> mem[$past(wr_phys)] == $past(wr_data)); // R10
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DATA_W = 32,
  parameter int NGLOB  = 8,
  parameter int NPER   = 8,
  parameter int NWIN   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               rd_a_addr,
  output logic [DATA_W-1:0]        rd_a_data,
  input  logic [4:0]               rd_b_addr,
  output logic [DATA_W-1:0]        rd_b_data,
  input  logic                     wr_en,
  input  logic [4:0]               wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     save,
  input  logic                     restore,
  output logic [$clog2(NWIN)-1:0]  cwp,
  output logic                     ovf,
  output logic                     unf
);
  localparam int CWP_W  = $clog2(NWIN);
  localparam int ARCH_W = 5;
  localparam int PHYS   = NGLOB + NWIN * 2 * NPER;
  localparam int PHYS_W = $clog2(PHYS);
  localparam int NRD    = 2;

  logic [NRD-1:0][ARCH_W-1:0] rd_arch;
  logic [NRD-1:0][PHYS_W-1:0] rd_phys;
  logic [NRD-1:0][DATA_W-1:0] rd_data;
  logic [PHYS_W-1:0]          wr_phys;

  assign rd_arch[0] = rd_a_addr;
  assign rd_arch[1] = rd_b_addr;
  assign rd_a_data  = rd_data[0];
  assign rd_b_data  = rd_data[1];

  rwf_winctl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
    .clk(clk), .rst_n(rst_n), .save(save), .restore(restore),
    .cwp(cwp), .ovf(ovf), .unf(unf)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rx
    rwf_xlate #(.NGLOB(NGLOB), .NPER(NPER), .NWIN(NWIN), .ARCH_W(ARCH_W),
                .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_rx (
      .arch(rd_arch[p]), .cwp(cwp), .phys(rd_phys[p])
    );
  end

  rwf_xlate #(.NGLOB(NGLOB), .NPER(NPER), .NWIN(NWIN), .ARCH_W(ARCH_W),
              .CWP_W(CWP_W), .PHYS_W(PHYS_W)) u_wx (
    .arch(wr_addr), .cwp(cwp), .phys(wr_phys)
  );

  rwf_store #(.DATA_W(DATA_W), .PHYS(PHYS), .PHYS_W(PHYS_W), .NRD(NRD)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_phys(wr_phys),
    .wr_data(wr_data), .rd_phys(rd_phys), .rd_data(rd_data)
  );

  AST_GLOBAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_a_addr) < NGLOB |-> 32'(rd_phys[0]) == 32'(rd_a_addr)); // R3
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf)); // R11
endmodule

// File: tb/regwin_file_test.sv
module regwin_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, save = 1'b0, restore = 1'b0;
  logic [2:0]  cwp;
  logic        ovf, unf;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  bit [31:0] m_glob [8];
  bit [31:0] m_loc  [8][8];
  bit [31:0] m_in   [8][8];
  int m_cwp = 0, m_depth = 0;
  bit m_ovf = 0, m_unf = 0;

  regwin_file uut (
    .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .save(save), .restore(restore),
    .cwp(cwp), .ovf(ovf), .unf(unf)
  );

  always #10 clk = ~clk;

  function automatic bit [31:0] mread(int a);
    int g = (a - 8) / 8;
    int k = a % 8;
    if (a == 0) return 0;
    if (a < 8)  return m_glob[a];
    if (g == 0) return m_in[(m_cwp + 7) % 8][k];
    if (g == 1) return m_loc[m_cwp][k];
    return m_in[m_cwp][k];
  endfunction

  function automatic bit [31:0] mport(int a);
    if (wr_en && wr_addr != 0 && int'(wr_addr) == a) return wr_data; // R9
    return mread(a);
  endfunction

  task automatic mwrite(int a, bit [31:0] d);
    int g = (a - 8) / 8;
    int k = a % 8;
    if (a == 0) return;
    if (a < 8) m_glob[a] = d;
    else if (g == 0) m_in[(m_cwp + 7) % 8][k] = d;
    else if (g == 1) m_loc[m_cwp][k] = d;
    else m_in[m_cwp][k] = d;
  endtask

  task automatic chk(string tg, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  task automatic step(bit sv, bit rs, bit we, int wa, bit [31:0] wd,
                      int ra, int rb, string tg);
    @(negedge clk);
    save = sv; restore = rs; wr_en = we;
    wr_addr = 5'(wa); wr_data = wd;
    rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
    #2;
    chk(tg, "rd_a", rd_a_data, mport(ra));
    chk(tg, "rd_b", rd_b_data, mport(rb));
    chk(tg, "cwp", cwp, m_cwp);
    chk(tg, "ovf", ovf, m_ovf);
    chk(tg, "unf", unf, m_unf);
    @(posedge clk);
    if (we) mwrite(wa, wd);               // R10 pre-move pointer
    m_ovf = 0; m_unf = 0;
    if (sv && !rs) begin
      if (m_depth == 6) m_ovf = 1;
      else begin m_cwp = (m_cwp + 7) % 8; m_depth++; end
    end else if (rs && !sv) begin
      if (m_depth == 0) m_unf = 1;
      else begin m_cwp = (m_cwp + 1) % 8; m_depth--; end
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // R1: reset state
    rd_a_addr = 5'd17; rd_b_addr = 5'd3;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "rd_a", rd_a_data, 0);
    chk("R1", "rd_b", rd_b_data, 0);
    chk("R1", "cwp", cwp, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "unf", unf, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: register zero
    step(0, 0, 1, 0, 32'hDEAD, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");

    // R3: globals across windows
    step(0, 0, 1, 5, 32'h55, 5, 1, "R3");
    step(1, 0, 1, 7, 32'h77, 5, 7, "R3");
    step(1, 0, 0, 0, 0, 5, 7, "R3");
    step(0, 1, 0, 0, 0, 5, 7, "R3");
    step(0, 1, 0, 0, 0, 5, 7, "R3");

    // R4: outputs become inputs, locals private
    for (int i = 0; i < 8; i++) step(0, 0, 1, 8 + i, 32'h100 + i, 8 + i, 16, "R4");
    step(0, 0, 1, 16, 32'hAA, 16, 8, "R4");
    step(1, 0, 0, 0, 0, 24, 16, "R4");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 24 + i, 16 + i, "R4");
    step(0, 1, 0, 0, 0, 16, 8, "R4");
    step(0, 0, 0, 0, 0, 16, 15, "R4");

    // R9: write-first bypass on both ports
    step(0, 0, 1, 20, 32'hBEEF, 20, 20, "R9");
    step(0, 0, 0, 0, 0, 20, 0, "R9");

    // R10: write in the same cycle as a window move
    step(1, 0, 1, 17, 32'h1717, 17, 31, "R10");
    step(0, 0, 0, 0, 0, 17, 31, "R10");
    step(0, 1, 1, 9, 32'h0909, 9, 25, "R10");
    step(0, 0, 0, 0, 0, 17, 9, "R10");

    // R5 and R6: run into overflow, R11: flag lasts one cycle
    for (int i = 0; i < 9; i++) step(1, 0, 0, 0, 0, 24, 8, "R6");
    step(0, 0, 0, 0, 0, 24, 8, "R11");
    step(0, 0, 0, 0, 0, 24, 8, "R11");

    // R8: both commands together
    step(1, 1, 0, 0, 0, 16, 24, "R8");
    step(0, 0, 0, 0, 0, 16, 24, "R8");

    // R5 and R7: unwind into underflow
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 0, 8, 16, "R7");
    step(0, 0, 0, 0, 0, 8, 16, "R11");

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int c = int'($urandom_range(0, 9));
      step(c == 0, c == 1 || c == 9, c > 3, int'($urandom_range(0, 31)),
           $urandom, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), "R5");
    end
    finish_run();
  end
endmodule